// File: doc/BRIEF.md
# Hardware Loop and Return-Address Sequencer

This block is the part of a program sequencer that chooses the next fetch address when hardware loops, subroutine calls, interrupts and returns are involved. Each cycle it takes the current fetch PC and one decoded flow command, together with that command's condition result and operands. It produces the next fetch PC in the same cycle. Call return addresses, interrupt return addresses and the loop start address all live in one 30-deep LIFO of return addresses.

A loop command records the address of the instruction after itself as the loop start. It pushes that address and loads a repeat count and the address of the last instruction of the body. Whenever the fetch PC reaches that last address, the block sends fetch back to the start with no branch instruction, until the count runs out. Any taken jump abandons the loop. One loop level is supported. The loop controller is a two-state machine. LP_IDLE moves to LP_RUN on an accepted loop start. LP_RUN moves back to LP_IDLE when the final pass ends or a jump aborts the loop. In every other case LP_RUN stays put.

Command codes on `cmd`: 0 none, 1 loop, 2 call, 3 return, 4 interrupt, 5 return-from-interrupt, 6 jump. Target mode codes on `tgt_mode`: 0 direct (`tgt_imm`), 1 indirect (`tgt_reg`), 2 PC-relative (`fetch_pc` + `tgt_imm`, modulo 2^24), 3 treated as direct.

Top module: `zol_sequencer`

## Requirements
- R1: After reset the stack is empty, not full, both error flags are clear and `lce` is 0. With `cmd` = 0, `next_pc` is `fetch_pc` + 1.
- R2: A taken call (code 2) pushes `fetch_pc` + 1 and sets `next_pc` to the target. A taken return (code 3) sets `next_pc` to the most recently pushed address and pops it, in last-in first-out order.
- R3: The stack holds 30 entries and raises `stk_full` at 30. A push onto a full stack is ignored, leaving the contents unchanged. It sets `stk_overflow`, which stays set until reset.
- R4: A taken return with an empty stack gives `next_pc` = `fetch_pc` + 1. It sets `stk_underflow`, which stays set until reset.
- R5: The call and jump target is `tgt_imm` for mode 0, `tgt_reg` for mode 1, and `fetch_pc` + `tgt_imm` (wrapping) for mode 2.
- R6: With `cmd_cond` = 0, a loop, call, return, return-from-interrupt or jump command has no effect: `next_pc` is `fetch_pc` + 1 and the stack is unchanged.
- R7: A taken loop command (code 1) with no loop active pushes `fetch_pc` + 1 as the loop start. It loads the counter from `loop_count`, where 0 counts as 1, and latches `loop_end`. `next_pc` is `fetch_pc` + 1.
- R8: With a loop active and no taken command, when `fetch_pc` equals the latched end address and the counter is above 1, `next_pc` is the loop start and the counter decrements.
- R9: At the end address with the counter at 1, `next_pc` is `fetch_pc` + 1, the loop entry is popped and the loop ends. `lce` is 1 exactly while a loop is active with the counter at 1.
- R10: A taken jump (code 6) while a loop is active pops the loop entry and ends the loop. Reaching the old end address afterwards falls through.
- R11: An interrupt (code 4) is taken regardless of `cmd_cond`. It pushes `fetch_pc` itself and sets `next_pc` to `int_vector`. Return-from-interrupt (code 5) returns to the pushed address.
- R12: A loop command while a loop is active is ignored. A loop command with a full stack does not start a loop and sets `stk_overflow`.
- R13: A taken command at the loop end address takes priority over the loop wrap, and the counter is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_pc | input | 24 | Address of the instruction being fetched |
| cmd | input | 3 | Decoded flow command code |
| cmd_cond | input | 1 | Condition of the command is true |
| tgt_mode | input | 2 | Target addressing mode |
| tgt_imm | input | 24 | Immediate target or PC-relative offset |
| tgt_reg | input | 24 | Register-supplied target |
| loop_count | input | 16 | Repeat count for a loop command |
| loop_end | input | 24 | Address of the last instruction of the loop body |
| int_vector | input | 24 | Interrupt service entry address |
| next_pc | output | 24 | Next fetch address |
| lce | output | 1 | Loop counter expired: final pass of the active loop |
| stk_empty | output | 1 | Return-address stack is empty |
| stk_full | output | 1 | Return-address stack holds 30 entries |
| stk_overflow | output | 1 | Sticky: a push was refused on a full stack |
| stk_underflow | output | 1 | Sticky: a pop was requested on an empty stack |

## Verification
`next_pc` is combinational from the inputs and the registered loop and stack state. It is therefore due in the same cycle as the command. The bench drives each command at the falling edge and compares `next_pc` 1 ns later, before the rising edge commits anything. Stack status, the sticky flags and `lce` change on the rising edge that consumes the command. They are compared at the following falling edge. Loop counting is observed only through `next_pc` at the end address and through `lce` on the pass that should be last.

// File: rtl/zol_seq_pkg.sv
package zol_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_LOOP = 3'd1,
        CMD_CALL = 3'd2,
        CMD_RET  = 3'd3,
        CMD_INT  = 3'd4,
        CMD_RTI  = 3'd5,
        CMD_JUMP = 3'd6
    } flow_cmd_e;

    typedef enum logic [1:0] {
        TGT_DIRECT   = 2'd0,
        TGT_INDIRECT = 2'd1,
        TGT_RELATIVE = 2'd2
    } tgt_mode_e;

    typedef enum logic {
        LP_IDLE = 1'b0,
        LP_RUN  = 1'b1
    } loop_state_e;

endpackage

// File: rtl/zol_target_gen.sv
module zol_target_gen
    import zol_seq_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic [1:0]    mode,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] imm,
    input  logic [AW-1:0] regv,
    output logic [AW-1:0] target,
    output logic [AW-1:0] pc_inc
);

    always_comb begin
        pc_inc = pc + AW'(1);
        unique case (tgt_mode_e'(mode))
            TGT_INDIRECT: target = regv;
            TGT_RELATIVE: target = pc + imm;
            default:      target = imm;
        endcase
    end

endmodule

// File: rtl/zol_pc_stack.sv
module zol_pc_stack #(
    parameter int AW    = 24,
    parameter int DEPTH = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] top,
    output logic          empty,
    output logic          full,
    output logic          ovf,
    output logic          unf
);

    localparam int PW = $clog2(DEPTH + 1);

    logic [AW-1:0] mem [DEPTH];
    logic [PW-1:0] level;
    logic [PW-1:0] top_idx;

    assign empty   = (level == '0);
    assign full    = (level == PW'(DEPTH));
    assign top_idx = level - PW'(1);
    assign top     = empty ? '0 : mem[top_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
        end else if (push) begin
            if (full) ovf   <= 1'b1;
            else      level <= level + PW'(1);
        end else if (pop) begin
            if (empty) unf   <= 1'b1;
            else       level <= level - PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[level] <= din;
    end

    // R3: depth never exceeds the configured size
    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= PW'(DEPTH));
    // R3: refused push leaves depth alone and raises the sticky flag
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> ($stable(level) && ovf));
    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    // R4: pop on empty keeps it empty and flags underflow
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> (empty && unf));
    assert_unf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        unf |=> unf);

endmodule

// File: rtl/zol_loop_ctrl.sv
module zol_loop_ctrl
    import zol_seq_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] end_addr,
    input  logic          abort,
    input  logic          hold,
    input  logic [AW-1:0] fetch_pc,
    output logic          active,
    output logic          wrap,
    output logic          finish,
    output logic          lce
);

    loop_state_e   state, state_nx;
    logic [CW-1:0] cnt;
    logic [AW-1:0] end_reg;
    logic          at_end;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LP_IDLE;
        else        state <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        active   = (state == LP_RUN);
        at_end   = 1'b0;
        wrap     = 1'b0;
        finish   = 1'b0;
        lce      = 1'b0;
        unique case (state)
            LP_IDLE: begin
                if (start) state_nx = LP_RUN;
            end
            LP_RUN: begin
                at_end = (fetch_pc == end_reg) && !hold;
                wrap   = at_end && (cnt != CW'(1));
                finish = at_end && (cnt == CW'(1));
                lce    = (cnt == CW'(1));
                if (abort || finish) state_nx = LP_IDLE;
            end
            default: state_nx = LP_IDLE;
        endcase
    end

    // counter and end-address registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            end_reg <= '0;
        end else if (state == LP_IDLE && start) begin
            cnt     <= (count == '0) ? CW'(1) : count;
            end_reg <= end_addr;
        end else if (wrap) begin
            cnt     <= cnt - CW'(1);
        end
    end

    // R8: a running loop never holds a zero count
    assert_run_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LP_RUN) |-> (cnt != '0));
    assert_wrap_dec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == $past(cnt) - CW'(1)));
    // R9: final pass returns the controller to idle
    assert_finish_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (state == LP_IDLE));
    // R10: abort ends the loop
    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && active) |=> !active);
    // R13: a held cycle leaves the counter alone
    assert_hold_keeps_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (active && hold && !abort) |=> $stable(cnt));

endmodule

// File: rtl/zol_sequencer.sv
module zol_sequencer
    import zol_seq_pkg::*;
#(
    parameter int AW    = 24,
    parameter int CW    = 16,
    parameter int DEPTH = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] fetch_pc,
    input  logic [2:0]    cmd,
    input  logic          cmd_cond,
    input  logic [1:0]    tgt_mode,
    input  logic [AW-1:0] tgt_imm,
    input  logic [AW-1:0] tgt_reg,
    input  logic [CW-1:0] loop_count,
    input  logic [AW-1:0] loop_end,
    input  logic [AW-1:0] int_vector,
    output logic [AW-1:0] next_pc,
    output logic          lce,
    output logic          stk_empty,
    output logic          stk_full,
    output logic          stk_overflow,
    output logic          stk_underflow
);

    flow_cmd_e     op;
    logic          taken;
    logic [AW-1:0] target, pc_inc, stk_top, push_d;
    logic          push_req, pop_req, loop_start, loop_abort;
    logic          lp_active, lp_wrap, lp_finish;

    assign op    = flow_cmd_e'(cmd);
    assign taken = (op == CMD_INT) || ((op != CMD_NONE) && cmd_cond);

    zol_target_gen #(.AW(AW)) u_tgt (
        .mode   (tgt_mode),
        .pc     (fetch_pc),
        .imm    (tgt_imm),
        .regv   (tgt_reg),
        .target (target),
        .pc_inc (pc_inc)
    );

    zol_pc_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_req),
        .pop   (pop_req),
        .din   (push_d),
        .top   (stk_top),
        .empty (stk_empty),
        .full  (stk_full),
        .ovf   (stk_overflow),
        .unf   (stk_underflow)
    );

    zol_loop_ctrl #(.AW(AW), .CW(CW)) u_loop (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (loop_start),
        .count    (loop_count),
        .end_addr (loop_end),
        .abort    (loop_abort),
        .hold     (taken),
        .fetch_pc (fetch_pc),
        .active   (lp_active),
        .wrap     (lp_wrap),
        .finish   (lp_finish),
        .lce      (lce)
    );

    always_comb begin
        next_pc    = pc_inc;
        push_req   = 1'b0;
        pop_req    = 1'b0;
        push_d     = pc_inc;
        loop_start = 1'b0;
        loop_abort = 1'b0;
        if (taken) begin
            unique case (op)
                CMD_LOOP: begin
                    if (!lp_active) begin
                        push_req   = 1'b1;
                        loop_start = !stk_full;
                    end
                end
                CMD_CALL: begin
                    push_req = 1'b1;
                    next_pc  = target;
                end
                CMD_INT: begin
                    push_req = 1'b1;
                    push_d   = fetch_pc;
                    next_pc  = int_vector;
                end
                CMD_RET, CMD_RTI: begin
                    pop_req = 1'b1;
                    if (!stk_empty) next_pc = stk_top;
                end
                CMD_JUMP: begin
                    next_pc    = target;
                    loop_abort = lp_active;
                    pop_req    = lp_active;
                end
                default: ;
            endcase
        end else if (lp_wrap) begin
            next_pc = stk_top;
        end else if (lp_finish) begin
            pop_req = 1'b1;
        end
    end

    // R7: an accepted loop start leaves its entry on the stack
    assert_loop_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        loop_start |=> !stk_empty);
    // R6: an untaken command requests no stack traffic
    assert_untaken_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!taken && !lp_finish) |-> !(push_req || pop_req));
    // R12: no second loop start while one is running
    assert_single_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lp_active |-> !loop_start);

endmodule

// File: tb/zol_sequencer_bench.sv
`timescale 1ns/1ps
module zol_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] fetch_pc = '0;
    logic [2:0]  cmd = '0;
    logic        cmd_cond = 1'b0;
    logic [1:0]  tgt_mode = '0;
    logic [23:0] tgt_imm = '0;
    logic [23:0] tgt_reg = '0;
    logic [15:0] loop_count = '0;
    logic [23:0] loop_end = '0;
    logic [23:0] int_vector = 24'h000800;
    logic [23:0] next_pc;
    logic        lce, stk_empty, stk_full, stk_overflow, stk_underflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    zol_sequencer u_zol_sequencer (
        .clk, .rst_n, .fetch_pc, .cmd, .cmd_cond, .tgt_mode, .tgt_imm,
        .tgt_reg, .loop_count, .loop_end, .int_vector, .next_pc, .lce,
        .stk_empty, .stk_full, .stk_overflow, .stk_underflow
    );

    // fields: cmd[101:99] cond[98] mode[97:96] pc[95:72] imm[71:48] reg[47:24] exp[23:0]
    localparam logic [101:0] VEC [13] = '{
        {3'd0, 1'b0, 2'd0, 24'h100, 24'h0,      24'h0,   24'h101}, // R1
        {3'd2, 1'b1, 2'd0, 24'h101, 24'h200,    24'h0,   24'h200}, // R2 R5 direct
        {3'd2, 1'b1, 2'd2, 24'h200, 24'h010,    24'h0,   24'h210}, // R5 relative
        {3'd2, 1'b0, 2'd0, 24'h210, 24'h300,    24'h0,   24'h211}, // R6 call not taken
        {3'd2, 1'b1, 2'd1, 24'h211, 24'h0,      24'h400, 24'h400}, // R5 indirect
        {3'd3, 1'b1, 2'd0, 24'h400, 24'h0,      24'h0,   24'h212}, // R2 return
        {3'd3, 1'b0, 2'd0, 24'h212, 24'h0,      24'h0,   24'h213}, // R6 return not taken
        {3'd4, 1'b0, 2'd0, 24'h213, 24'h0,      24'h0,   24'h800}, // R11 interrupt
        {3'd5, 1'b1, 2'd0, 24'h800, 24'h0,      24'h0,   24'h213}, // R11 return from interrupt
        {3'd3, 1'b1, 2'd0, 24'h213, 24'h0,      24'h0,   24'h201}, // R2 LIFO
        {3'd3, 1'b1, 2'd0, 24'h201, 24'h0,      24'h0,   24'h102}, // R2 LIFO
        {3'd3, 1'b1, 2'd0, 24'h102, 24'h0,      24'h0,   24'h103}, // R4 empty return
        {3'd6, 1'b1, 2'd2, 24'h103, 24'hFFFFF0, 24'h0,   24'h0F3}  // R5 relative jump wraps
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one command at the falling edge, compare next_pc, consume it
    task automatic step(input logic [2:0] c, input logic cnd, input logic [1:0] m,
                        input logic [23:0] pc, input logic [23:0] imm, input logic [23:0] rg,
                        input logic [15:0] lc, input logic [23:0] le,
                        input logic [23:0] exp, input string req);
        cmd = c; cmd_cond = cnd; tgt_mode = m; fetch_pc = pc;
        tgt_imm = imm; tgt_reg = rg; loop_count = lc; loop_end = le;
        #1;
        chk(req, {8'h0, next_pc}, {8'h0, exp});
        @(negedge clk);
        cmd = 3'd0; cmd_cond = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cmd = 3'd0; cmd_cond = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 empty", stk_empty, 1);
        chk("R1 full", stk_full, 0);
        chk("R1 overflow", stk_overflow, 0);
        chk("R1 underflow", stk_underflow, 0);
        chk("R1 lce", lce, 0);

        for (int i = 0; i < 13; i++) begin
            step(VEC[i][101:99], VEC[i][98], VEC[i][97:96], VEC[i][95:72],
                 VEC[i][71:48], VEC[i][47:24], 16'd0, 24'h0, VEC[i][23:0],
                 $sformatf("R2/R5/R6/R11 table step %0d", i));
        end
        chk("R4 underflow sticky", stk_underflow, 1);
        chk("R4 still empty", stk_empty, 1);

        // R7 R8 R9: three passes of a 3-instruction body
        step(3'd1, 1, 0, 24'h100, 0, 0, 16'd3, 24'h103, 24'h101, "R7 loop start");
        chk("R9 lce early", lce, 0);
        chk("R7 pushed", stk_empty, 0);
        step(3'd0, 0, 0, 24'h101, 0, 0, 0, 0, 24'h102, "R8 body");
        step(3'd0, 0, 0, 24'h102, 0, 0, 0, 0, 24'h103, "R8 body");
        step(3'd0, 0, 0, 24'h103, 0, 0, 0, 0, 24'h101, "R8 wrap 1");
        step(3'd0, 0, 0, 24'h103, 0, 0, 0, 0, 24'h101, "R8 wrap 2");
        chk("R9 lce last pass", lce, 1);
        step(3'd0, 0, 0, 24'h103, 0, 0, 0, 0, 24'h104, "R9 fall through");
        chk("R9 popped", stk_empty, 1);
        chk("R9 lce cleared", lce, 0);

        // R7 count 0 acts as one pass
        step(3'd1, 1, 0, 24'h0FF, 0, 0, 16'd0, 24'h100, 24'h100, "R7 count zero start");
        chk("R7 count zero lce", lce, 1);
        step(3'd0, 0, 0, 24'h100, 0, 0, 0, 0, 24'h101, "R7 count zero single pass");
        chk("R7 count zero popped", stk_empty, 1);

        // R10 jump aborts the loop
        step(3'd1, 1, 0, 24'h100, 0, 0, 16'd5, 24'h103, 24'h101, "R10 loop start");
        step(3'd6, 1, 0, 24'h101, 24'h500, 0, 0, 0, 24'h500, "R10 jump");
        chk("R10 loop entry popped", stk_empty, 1);
        step(3'd0, 0, 0, 24'h103, 0, 0, 0, 0, 24'h104, "R10 no wrap after abort");

        // R13 taken command at the end address wins over the wrap
        step(3'd1, 1, 0, 24'h100, 0, 0, 16'd2, 24'h103, 24'h101, "R13 loop start");
        step(3'd2, 1, 0, 24'h103, 24'h600, 0, 0, 0, 24'h600, "R13 call at end");
        step(3'd3, 1, 0, 24'h600, 0, 0, 0, 0, 24'h104, "R13 return");
        chk("R13 counter untouched", lce, 0);
        step(3'd0, 0, 0, 24'h103, 0, 0, 0, 0, 24'h101, "R13 wrap after call");
        chk("R13 lce last", lce, 1);
        step(3'd0, 0, 0, 24'h103, 0, 0, 0, 0, 24'h104, "R13 finish");
        chk("R13 empty", stk_empty, 1);

        // R12 nested loop command ignored
        step(3'd1, 1, 0, 24'h100, 0, 0, 16'd2, 24'h103, 24'h101, "R12 loop start");
        step(3'd1, 1, 0, 24'h101, 0, 0, 16'd9, 24'h200, 24'h102, "R12 inner loop ignored");
        step(3'd0, 0, 0, 24'h103, 0, 0, 0, 0, 24'h101, "R12 old end kept");
        step(3'd0, 0, 0, 24'h103, 0, 0, 0, 0, 24'h104, "R12 old count kept");
        chk("R12 no extra push", stk_empty, 1);

        // R3 overflow
        do_reset();
        for (int i = 0; i < 30; i++) begin
            step(3'd2, 1, 0, 24'(i), 24'h900, 0, 0, 0, 24'h900, "R3 fill call");
        end
        chk("R3 full", stk_full, 1);
        chk("R3 no overflow yet", stk_overflow, 0);
        step(3'd2, 1, 0, 24'h777, 24'h900, 0, 0, 0, 24'h900, "R3 call on full");
        chk("R3 overflow set", stk_overflow, 1);
        // R12 loop on full stack does not start
        step(3'd1, 1, 0, 24'h050, 0, 0, 16'd2, 24'h051, 24'h051, "R12 loop on full");
        step(3'd0, 0, 0, 24'h051, 0, 0, 0, 0, 24'h052, "R12 no loop started");
        chk("R12 lce", lce, 0);
        for (int i = 30; i >= 1; i--) begin
            step(3'd3, 1, 0, 24'h900, 0, 0, 0, 0, 24'(i), "R3 contents intact");
        end
        chk("R3 drained", stk_empty, 1);
        chk("R3 overflow sticky", stk_overflow, 1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule